// File: doc/BRIEF.md
# Omega Multistage Interconnect Router

This block is a self-routing interconnection network that joins eight requesters to eight memory ports. It is built from three columns of 2x2 switch elements, four switches per column. A perfect shuffle of the link indices comes before every column. Each requester presents a valid flag, a 3-bit destination port number and a data payload. Every switch reads one bit of the destination and steers the packet to its upper or lower output, so a packet finds its memory port without any central arbiter. Every column is followed by a register, and one new set of requests can enter on each clock.

Any requester can reach any memory port. Some permutations of requests still collide inside the network, because two packets may need the same switch output at the same stage. The switch then passes the packet that arrived on its lower-numbered input and drops the other one. The network raises a per-requester blocked flag, in the same cycle in which that request would have reached memory, so the requester can retry later. Blocked packets are not buffered, and requests to the same port are not combined.

Top module: `omega_router`

## Requirements
- R1: While reset is low, and on the first clock after it, every bit of out_valid and out_blocked is 0, whatever the inputs carry.
- R2: A packet that is not blocked appears on out_valid/out_data at the port equal to its 3-bit in_dest value (binary 000 = port 0 through 111 = port 7). It carries its own in_data, and this holds for every input port.
- R3: The column with stage index k (0, 1, 2, counted from the inputs) steers on destination bit 2-k. A 0 sends the packet to the upper output (the even link) and a 1 sends it to the lower output (the odd link). Before every column, link i moves to link ((i << 1) | (i >> 2)) mod 8.
- R4: When both inputs of a switch hold valid packets that steer to the same output, the packet on the even (lower-numbered) input link goes on. The other packet is dropped, and out_blocked[r] is set for its requester r.
- R5: Every valid request is either delivered to exactly one port or reported as blocked, never both. The number of set out_valid bits plus the number of set out_blocked bits equals the number of valid requests three cycles earlier.
- R6: A result is visible exactly 3 clock cycles after its request is presented, and not earlier. The network accepts a new request set on every cycle.
- R7: A port that receives no packet shows out_valid = 0 and out_data = 0.
- R8: The identity, the complement (dest = 7 - i) and the cyclic shifts (dest = (i + c) mod 8) are delivered in full with no blocked flag.
- R9: The bit-reversal pattern (dest = bits of i reversed), with all eight requests valid, reaches only ports 0, 2, 4 and 6. Requesters 4 to 7 are blocked.
- R10: An input whose in_valid is 0 produces no output and no blocked flag, whatever its in_dest and in_data hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Request present, one bit per requester |
| in_dest | input | 8x3 | Destination memory port, per requester |
| in_data | input | 8x16 | Payload, per requester |
| out_valid | output | 8 | Packet delivered, one bit per memory port |
| out_data | output | 8x16 | Payload of the delivered packet, per memory port |
| out_blocked | output | 8 | Request dropped in a conflict, one bit per requester |

## Verification
Every result of this block is due 3 clock edges after its request is driven. That covers the delivered packet, its payload, the zeroed idle ports and the per-requester blocked flags. The bench drives inputs on the falling edge and samples exactly three falling edges later. The latency test also samples one and two edges after a single-cycle request, to confirm that nothing appears early, and one edge after the expected result, to confirm that nothing stays behind. For back-to-back tests, two request sets go in on consecutive cycles and the checks fall on consecutive cycles, so each result is matched to its own request. Expected ports and losers come from a bench model. The model tracks each packet's link position as a shifted index and settles each collision by the top bit of the link the packet came from.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle wiring: one-bit left rotation of a link index
  function automatic int unsigned shuffle_idx(input int unsigned idx,
                                              input int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

  // Destination bit consumed by a given column (MSB first)
  function automatic int unsigned stage_bit(input int unsigned stage,
                                            input int unsigned bits);
    return bits - 1 - stage;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int AW  = 3,
  parameter int W   = 16,
  parameter int BIT = 2
) (
  input  logic          up_v,
  input  logic [AW-1:0] up_dest,
  input  logic [AW-1:0] up_src,
  input  logic [W-1:0]  up_data,
  input  logic          lo_v,
  input  logic [AW-1:0] lo_dest,
  input  logic [AW-1:0] lo_src,
  input  logic [W-1:0]  lo_data,
  output logic          o0_v,
  output logic [AW-1:0] o0_dest,
  output logic [AW-1:0] o0_src,
  output logic [W-1:0]  o0_data,
  output logic          o1_v,
  output logic [AW-1:0] o1_dest,
  output logic [AW-1:0] o1_src,
  output logic [W-1:0]  o1_data,
  output logic          lo_lost
);

  logic up_bit, lo_bit;
  assign up_bit  = up_dest[BIT];
  assign lo_bit  = lo_dest[BIT];
  // contention event: both valid and both steer the same way
  assign lo_lost = up_v & lo_v & (up_bit == lo_bit);

  always_comb begin
    o0_v = 1'b0; o0_dest = '0; o0_src = '0; o0_data = '0;
    o1_v = 1'b0; o1_dest = '0; o1_src = '0; o1_data = '0;
    if (up_v && !up_bit) begin
      o0_v = 1'b1; o0_dest = up_dest; o0_src = up_src; o0_data = up_data;
    end else if (lo_v && !lo_bit) begin
      o0_v = 1'b1; o0_dest = lo_dest; o0_src = lo_src; o0_data = lo_data;
    end
    if (up_v && up_bit) begin
      o1_v = 1'b1; o1_dest = up_dest; o1_src = up_src; o1_data = up_data;
    end else if (lo_v && lo_bit) begin
      o1_v = 1'b1; o1_dest = lo_dest; o1_src = lo_src; o1_data = lo_data;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 3,
  parameter int W     = 16,
  parameter int STAGE = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          i_v,
  input  logic [N-1:0][AW-1:0]  i_dest,
  input  logic [N-1:0][AW-1:0]  i_src,
  input  logic [N-1:0][W-1:0]   i_data,
  input  logic [N-1:0]          i_blk,
  output logic [N-1:0]          q_v,
  output logic [N-1:0][AW-1:0]  q_dest,
  output logic [N-1:0][AW-1:0]  q_src,
  output logic [N-1:0][W-1:0]   q_data,
  output logic [N-1:0]          q_blk
);

  localparam int BIT = int'(stage_bit(STAGE, AW));
  localparam int NSW = N / 2;

  logic [N-1:0]          s_v, w_v;
  logic [N-1:0][AW-1:0]  s_dest, s_src, w_dest, w_src;
  logic [N-1:0][W-1:0]   s_data, w_data;
  logic [N-1:0]          blk_next;
  logic [NSW-1:0]        lost;
  logic                  primed;

  // shuffle wiring ahead of the switch column
  always_comb begin
    s_v = '0; s_dest = '0; s_src = '0; s_data = '0;
    for (int i = 0; i < N; i++) begin
      s_v[shuffle_idx(i, AW)]    = i_v[i];
      s_dest[shuffle_idx(i, AW)] = i_dest[i];
      s_src[shuffle_idx(i, AW)]  = i_src[i];
      s_data[shuffle_idx(i, AW)] = i_data[i];
    end
  end

  for (genvar j = 0; j < NSW; j++) begin : g_sw
    omega_switch #(.AW(AW), .W(W), .BIT(BIT)) u_sw (
      .up_v   (s_v[2*j]),     .up_dest(s_dest[2*j]),
      .up_src (s_src[2*j]),   .up_data(s_data[2*j]),
      .lo_v   (s_v[2*j+1]),   .lo_dest(s_dest[2*j+1]),
      .lo_src (s_src[2*j+1]), .lo_data(s_data[2*j+1]),
      .o0_v   (w_v[2*j]),     .o0_dest(w_dest[2*j]),
      .o0_src (w_src[2*j]),   .o0_data(w_data[2*j]),
      .o1_v   (w_v[2*j+1]),   .o1_dest(w_dest[2*j+1]),
      .o1_src (w_src[2*j+1]), .o1_data(w_data[2*j+1]),
      .lo_lost(lost[j])
    );
  end

  // record dropped packets against their requester
  always_comb begin
    blk_next = i_blk;
    for (int j = 0; j < NSW; j++)
      if (lost[j]) blk_next[s_src[2*j+1]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v <= '0; q_dest <= '0; q_src <= '0; q_data <= '0; q_blk <= '0;
      primed <= 1'b0;
    end else begin
      q_v <= w_v; q_dest <= w_dest; q_src <= w_src; q_data <= w_data;
      q_blk <= blk_next;
      primed <= 1'b1;
    end
  end

  // R5: packets are neither created nor lost in a column
  a_r5_conserve: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($countones(q_v) + $countones(q_blk)) ==
    ($countones($past(i_v)) + $countones($past(i_blk))));

  for (genvar l = 0; l < N; l++) begin : g_chk
    // R3: a packet on an even link had a 0 in this column's bit
    a_r3_steer: assert property (@(posedge clk) disable iff (!rst_n)
      q_v[l] |-> (q_dest[l][BIT] == l[0]));
  end

  for (genvar j = 0; j < NSW; j++) begin : g_win
    // R4: on contention the even-link packet survives
    a_r4_upper_wins: assert property (@(posedge clk) disable iff (!rst_n)
      lost[j] |=> (q_v[2*j + int'($past(s_dest[2*j][BIT]))] &&
                   q_src[2*j + int'($past(s_dest[2*j][BIT]))] == $past(s_src[2*j])));
  end

endmodule

// File: rtl/omega_router.sv
module omega_router
  import omega_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_PORTS-1:0]                   in_valid,
  input  logic [N_PORTS-1:0][$clog2(N_PORTS)-1:0] in_dest,
  input  logic [N_PORTS-1:0][DATA_W-1:0]       in_data,
  output logic [N_PORTS-1:0]                   out_valid,
  output logic [N_PORTS-1:0][DATA_W-1:0]       out_data,
  output logic [N_PORTS-1:0]                   out_blocked
);

  localparam int AW = $clog2(N_PORTS);
  localparam int NS = AW;

  logic [N_PORTS-1:0]          lv [NS+1];
  logic [N_PORTS-1:0][AW-1:0]  ld [NS+1];
  logic [N_PORTS-1:0][AW-1:0]  ls [NS+1];
  logic [N_PORTS-1:0][DATA_W-1:0] lp [NS+1];
  logic [N_PORTS-1:0]          lb [NS+1];

  assign lv[0] = in_valid;
  assign ld[0] = in_dest;
  assign lp[0] = in_data;
  assign lb[0] = '0;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    assign ls[0][i] = AW'(i);
  end

  for (genvar k = 0; k < NS; k++) begin : g_stage
    omega_stage #(.N(N_PORTS), .AW(AW), .W(DATA_W), .STAGE(k)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .i_v(lv[k]), .i_dest(ld[k]), .i_src(ls[k]), .i_data(lp[k]), .i_blk(lb[k]),
      .q_v(lv[k+1]), .q_dest(ld[k+1]), .q_src(ls[k+1]), .q_data(lp[k+1]),
      .q_blk(lb[k+1])
    );
  end

  // final-column destination brought out for the checks
  logic [N_PORTS-1:0][AW-1:0] fin_dest;
  assign fin_dest    = ld[NS];
  assign out_valid   = lv[NS];
  assign out_data    = lp[NS];
  assign out_blocked = lb[NS];

  logic [7:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm < 8'(NS)) warm <= warm + 8'd1;
  end

  // R6: anything leaving was presented NS cycles earlier
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n || warm < 8'(NS))
    (|out_valid) |-> (|$past(in_valid, NS)));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // R2: a delivered packet sits on the port it named
    a_r2_dest: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (fin_dest[p] == AW'(p)));
    // R7: idle ports carry zero payload
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[p] |-> (out_data[p] == '0));
    // R10: a blocked flag only for a request that was really made
    a_r10_blk_real: assert property (@(posedge clk) disable iff (!rst_n || warm < 8'(NS))
      out_blocked[p] |-> $past(in_valid[p], NS));
  end

endmodule

// File: tb/sim_omega_router.sv
`timescale 1ns/1ps
module sim_omega_router;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]       in_valid = '0;
  logic [7:0][2:0]  in_dest = '0;
  logic [7:0][15:0] in_data = '0;
  logic [7:0]       out_valid;
  logic [7:0][15:0] out_data;
  logic [7:0]       out_blocked;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  omega_router #(.N_PORTS(8), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_blocked(out_blocked));

  typedef struct packed {
    logic [1:0]      kind;   // 0 R8, 1 R9, 2 R4, 3 R10
    logic [7:0]      v;
    logic [7:0][2:0] d;
    logic [7:0]      e;
  } vec_t;

  localparam vec_t TABLE [7] = '{
    '{2'd0, 8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF},
    '{2'd2, 8'hFF, {3'd5,3'd5,3'd5,3'd5,3'd5,3'd5,3'd5,3'd5}, 8'h20},
    '{2'd0, 8'hFF, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'hFF},
    '{2'd0, 8'hFF, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, 8'hFF},
    '{2'd3, 8'h08, {3'd7,3'd7,3'd7,3'd7,3'd6,3'd7,3'd7,3'd7}, 8'h40},
    '{2'd1, 8'hFF, {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0}, 8'h55},
    '{2'd0, 8'hFF, {3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4,3'd3}, 8'hFF}
  };

  function automatic logic [15:0] dat(input int tag, input int i);
    return 16'((tag << 8) | (i * 17 + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: link position shifts left and takes the next dest bit;
  // a collision goes to the packet whose previous link had top bit 0
  task automatic model(input logic [7:0] v, input logic [7:0][2:0] d,
                       output logic [7:0] ev, output int esrc [8],
                       output logic [7:0] eblk);
    int pos [8];
    int np [8];
    bit alive [8];
    ev = '0; eblk = '0;
    for (int s = 0; s < 8; s++) begin
      pos[s] = s; alive[s] = v[s]; esrc[s] = 0;
    end
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 8; s++)
        np[s] = ((pos[s] << 1) & 7) | ((int'(d[s]) >> (2 - k)) & 1);
      for (int s = 0; s < 8; s++)
        for (int t = s + 1; t < 8; t++)
          if (alive[s] && alive[t] && np[s] == np[t]) begin
            if (((pos[s] >> 2) & 1) == 1) begin alive[s] = 0; eblk[s] = 1'b1; end
            else begin alive[t] = 0; eblk[t] = 1'b1; end
          end
      for (int s = 0; s < 8; s++) pos[s] = np[s];
    end
    for (int s = 0; s < 8; s++)
      if (alive[s]) begin ev[pos[s]] = 1'b1; esrc[pos[s]] = s; end
  endtask

  task automatic drive(input logic [7:0] v, input logic [7:0][2:0] d, input int tag);
    in_valid = v; in_dest = d;
    for (int i = 0; i < 8; i++) in_data[i] = dat(tag, i);
  endtask

  task automatic check_result(input logic [7:0] v, input logic [7:0][2:0] d,
                              input int tag);
    logic [7:0] ev, eb;
    int es [8];
    model(v, d, ev, es, eb);
    chk(out_valid == ev, "R2", "out_valid", int'(out_valid), int'(ev));
    for (int p = 0; p < 8; p++) begin
      if (ev[p])
        chk(out_data[p] == dat(tag, es[p]), "R2", "out_data",
            int'(out_data[p]), int'(dat(tag, es[p])));
      else
        chk(out_data[p] == 16'h0, "R7", "idle data", int'(out_data[p]), 0);
    end
    chk(out_blocked == eb, "R4", "out_blocked", int'(out_blocked), int'(eb));
    chk($countones(out_valid) + $countones(out_blocked) == $countones(v), "R5",
        "delivered+blocked", $countones(out_valid) + $countones(out_blocked),
        $countones(v));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_err++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
    finish_run();
  end

  initial begin
    logic [7:0][2:0] idn;
    logic [7:0][2:0] cmp;
    logic [7:0][2:0] al5;
    idn = TABLE[0].d; al5 = TABLE[1].d; cmp = TABLE[2].d;

    // R1: reset holds outputs low even with live inputs
    @(negedge clk);
    drive(8'hFF, idn, 1);
    repeat (4) @(negedge clk);
    chk(out_valid == 8'h0, "R1", "valid in reset", int'(out_valid), 0);
    chk(out_blocked == 8'h0, "R1", "blocked in reset", int'(out_blocked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 8'h0, "R1", "valid after reset", int'(out_valid), 0);
    drive(8'h00, idn, 0);
    repeat (4) @(negedge clk);

    // table walk: R8 R9 R4 R10 patterns
    for (int n = 0; n < 7; n++) begin
      drive(TABLE[n].v, TABLE[n].d, n + 2);
      repeat (3) @(negedge clk);
      check_result(TABLE[n].v, TABLE[n].d, n + 2);
      case (TABLE[n].kind)
        2'd0: chk(out_valid == TABLE[n].e && out_blocked == 0, "R8", "pattern",
                  int'(out_valid), int'(TABLE[n].e));
        2'd1: chk(out_valid == TABLE[n].e && out_blocked == 8'hF0, "R9", "bit reversal",
                  int'({out_blocked, out_valid}), int'({8'hF0, TABLE[n].e}));
        2'd2: chk(out_valid == TABLE[n].e && $countones(out_blocked) == 7, "R4",
                  "all to port 5", int'(out_blocked), 8'hFE);
        default: chk(out_valid == TABLE[n].e && out_blocked == 0, "R10", "single",
                     int'(out_valid), int'(TABLE[n].e));
      endcase
    end
    drive(8'h00, idn, 0);
    repeat (4) @(negedge clk);

    // R6: exact latency of a one-cycle request
    drive(8'hFF, idn, 20);
    @(negedge clk);
    drive(8'h00, idn, 0);
    chk(out_valid == 0, "R6", "early +1", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 0, "R6", "early +2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 8'hFF, "R6", "due +3", int'(out_valid), 8'hFF);
    @(negedge clk);
    chk(out_valid == 0, "R6", "gone +4", int'(out_valid), 0);

    // R6: back-to-back sets on consecutive cycles
    repeat (3) @(negedge clk);
    drive(8'hFF, cmp, 21);
    @(negedge clk);
    drive(8'hFF, al5, 22);
    @(negedge clk);
    drive(8'h00, idn, 0);
    @(negedge clk);
    check_result(8'hFF, cmp, 21);
    chk(out_valid == 8'hFF, "R6", "first of pair", int'(out_valid), 8'hFF);
    @(negedge clk);
    check_result(8'hFF, al5, 22);
    chk(out_valid == 8'h20, "R6", "second of pair", int'(out_valid), 8'h20);

    // R10: invalid inputs with colliding dests and junk data do nothing
    repeat (3) @(negedge clk);
    drive(8'h00, al5, 23);
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_blocked == 0, "R10", "all invalid",
        int'({out_blocked, out_valid}), 0);
    // R3: one packet from each input to an odd/even spread
    for (int i = 0; i < 8; i++) begin
      logic [7:0][2:0] dd;
      dd = '0;
      dd[i] = 3'(7 - i);
      drive(8'(1 << i), dd, 30 + i);
      repeat (3) @(negedge clk);
      chk(out_valid == 8'(1 << (7 - i)) && out_data[7 - i] == dat(30 + i, i), "R3",
          "single route", int'(out_valid), 1 << (7 - i));
    end

    // R1: reset mid-stream clears the pipeline
    drive(8'hFF, idn, 40);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && out_blocked == 0, "R1", "mid reset",
        int'({out_blocked, out_valid}), 0);
    rst_n = 1'b1;
    drive(8'h00, idn, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "after mid reset", int'(out_valid), 0);

    finish_run();
  end

endmodule